// File: doc/BRIEF.md
# Multi-Cycle One-Hot State Sequencer

This block is the control half of a scheduled datapath. It walks through a small set of states, one at a time, and keeps exactly one bit of its state register set. Each state can be held for a run-time programmed number of clock cycles, from 1 to 32. A single shared 5-bit cycle counter measures how long the current state has been active. Per-state end detectors compare that counter with the state's programmed duration code.

While a state is active, the block presents a registered multiplexer-select word for that state. The word is loaded when the state is entered and does not move until the state is left, so the datapath routes it steers stay still for the whole multi-cycle step. Register write enables and the end-of-state strobe are combinational. They are raised only in the final cycle of the state, so results are captured exactly once, after the datapath has had every cycle of the state to settle.

Successors come from two per-state tables. A one-bit condition input picks between them, and it is looked at only in a state's final cycle. All tables are plain input buses, so software-free control logic or a parent FSM can rewrite them at any time. The block has no data stream, so every pin is a plain level with no valid/ready handshake.

Top module: `mcyc_onehot_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `state_o` is `000001` (state 0), `cnt_o` is 0, `sel_o` equals the select entry of state 0, and `last_o` and `we_o` are 0 during reset.
- R2: `cnt_o` rises by one each cycle while a state is held and is 0 in the first cycle of every newly entered state.
- R3: A state whose duration code is d (field i of `dur_tbl_i` at bits [i*5 +: 5]) lasts exactly d+1 cycles, so code 0 gives 1 cycle and code 31 gives 32 cycles. `last_o` is high only when `cnt_o` equals d.
- R4: At the end of state i, the next state is the index in field i of `nxt1_tbl_i` when `cond_i` is 1, and the index in field i of `nxt0_tbl_i` otherwise. Fields are IDX_W bits wide at [i*IDX_W +: IDX_W]. `state_o` has bit k set for state k.
- R5: A successor index equal to or above N_STATES sends the sequencer to state 0.
- R6: `sel_o` is a register that holds field s of `sel_tbl_i` ([s*SEL_W +: SEL_W]), captured as state s is entered. It stays constant for the whole state even if the table changes meanwhile.
- R7: `we_o` equals field s of `we_tbl_i` ([s*WE_W +: WE_W]) in the final cycle of the current state s, in that same cycle, and is 0 in every other cycle.
- R8: `cond_i` has no effect in any cycle that is not the final cycle of a state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 1 | Branch condition, used in the final cycle of a state |
| dur_tbl_i | input | N_STATES*5 | Per-state duration codes (cycles minus one) |
| nxt0_tbl_i | input | N_STATES*IDX_W | Per-state successor taken when cond_i is 0 |
| nxt1_tbl_i | input | N_STATES*IDX_W | Per-state successor taken when cond_i is 1 |
| sel_tbl_i | input | N_STATES*SEL_W | Per-state multiplexer-select word |
| we_tbl_i | input | N_STATES*WE_W | Per-state write-enable mask |
| state_o | output | N_STATES | One-hot current state |
| cnt_o | output | 5 | Cycles spent in the current state |
| last_o | output | 1 | Final-cycle strobe of the current state |
| sel_o | output | SEL_W | Registered select word of the current state |
| we_o | output | WE_W | Write enables, final cycle only |

## Verification
Every cycle, the assertions check four things. The state register holds exactly one set bit. The state and select word hold still through any cycle that is not a final cycle. The counter steps by one inside a state and restarts after each final cycle. Any write enable is followed by a fresh state whose count is 0. Only the bench scenarios can show the values themselves. These are the exact length of each programmed duration, including the full 32-cycle case, and which successor the condition selects. They also cover the fallback to state 0 on an out-of-range index, a select word that ignores a mid-state table rewrite, and a condition pulse that is ignored outside a final cycle.

// File: rtl/mcyc_seq_pkg.sv
package mcyc_seq_pkg;
  localparam int CNT_W = 5;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/mcyc_seq_counter.sv
module mcyc_seq_counter
  import mcyc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output cnt_t cnt
);
  cnt_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + cnt_t'(1);
  end

  assign cnt = cnt_q;

  // R2: counting inside a state
  a_r2_step : assert property (@(posedge clk) disable iff (rst)
    !restart |=> cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1)));
  // R2: restart on state change
  a_r2_clear : assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/mcyc_seq_enddet.sv
module mcyc_seq_enddet
  import mcyc_seq_pkg::*;
#(
  parameter int N_STATES = 6,
  parameter int WE_W     = 4
) (
  input  logic [N_STATES-1:0]       st,
  input  cnt_t                      cnt,
  input  logic [N_STATES*CNT_W-1:0] dur_tbl,
  input  logic [N_STATES*WE_W-1:0]  we_tbl,
  output logic                      at_end,
  output logic [WE_W-1:0]           we
);
  logic [N_STATES-1:0] hit;
  logic [WE_W-1:0]     we_part [N_STATES];

  genvar gi;
  generate
    for (gi = 0; gi < N_STATES; gi++) begin : g_det
      assign hit[gi]     = st[gi] && (cnt == dur_tbl[gi*CNT_W +: CNT_W]);
      assign we_part[gi] = hit[gi] ? we_tbl[gi*WE_W +: WE_W] : '0;
    end
  endgenerate

  always_comb begin
    we = '0;
    for (int i = 0; i < N_STATES; i++) we = we | we_part[i];
  end

  assign at_end = |hit;
endmodule

// File: rtl/mcyc_seq_succ.sv
module mcyc_seq_succ #(
  parameter int N_STATES = 6,
  parameter int IDX_W    = 3,
  parameter int SEL_W    = 4
) (
  input  logic [N_STATES-1:0]       st,
  input  logic                      cond,
  input  logic [N_STATES*IDX_W-1:0] nxt0_tbl,
  input  logic [N_STATES*IDX_W-1:0] nxt1_tbl,
  input  logic [N_STATES*SEL_W-1:0] sel_tbl,
  output logic [N_STATES-1:0]       nxt_oh,
  output logic [SEL_W-1:0]          nxt_sel
);
  logic [IDX_W-1:0] pick [N_STATES];
  logic [IDX_W-1:0] tgt;

  genvar gi;
  generate
    for (gi = 0; gi < N_STATES; gi++) begin : g_pick
      assign pick[gi] = st[gi] ? (cond ? nxt1_tbl[gi*IDX_W +: IDX_W]
                                       : nxt0_tbl[gi*IDX_W +: IDX_W]) : '0;
    end
  endgenerate

  always_comb begin
    tgt = '0;
    for (int i = 0; i < N_STATES; i++) tgt = tgt | pick[i];
    nxt_oh = '0;
    if (int'(tgt) < N_STATES) nxt_oh[tgt] = 1'b1;
    else                      nxt_oh[0]   = 1'b1;
    nxt_sel = '0;
    for (int i = 0; i < N_STATES; i++)
      if (nxt_oh[i]) nxt_sel = nxt_sel | sel_tbl[i*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/mcyc_onehot_seq.sv
module mcyc_onehot_seq
  import mcyc_seq_pkg::*;
#(
  parameter int N_STATES = 6,
  parameter int IDX_W    = $clog2(N_STATES),
  parameter int SEL_W    = 4,
  parameter int WE_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cond_i,
  input  logic [N_STATES*CNT_W-1:0] dur_tbl_i,
  input  logic [N_STATES*IDX_W-1:0] nxt0_tbl_i,
  input  logic [N_STATES*IDX_W-1:0] nxt1_tbl_i,
  input  logic [N_STATES*SEL_W-1:0] sel_tbl_i,
  input  logic [N_STATES*WE_W-1:0]  we_tbl_i,
  output logic [N_STATES-1:0]       state_o,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      last_o,
  output logic [SEL_W-1:0]          sel_o,
  output logic [WE_W-1:0]           we_o
);
  localparam logic [N_STATES-1:0] ST_INIT = N_STATES'(1);

  logic [N_STATES-1:0] st_q;
  logic [SEL_W-1:0]    sel_q;
  cnt_t                cnt;
  logic                end_raw, last_w;
  logic [WE_W-1:0]     we_raw;
  logic [N_STATES-1:0] nxt_oh;
  logic [SEL_W-1:0]    nxt_sel;

  mcyc_seq_counter u_cnt (
    .clk(clk), .rst(rst), .restart(last_w), .cnt(cnt)
  );

  mcyc_seq_enddet #(.N_STATES(N_STATES), .WE_W(WE_W)) u_end (
    .st(st_q), .cnt(cnt), .dur_tbl(dur_tbl_i), .we_tbl(we_tbl_i),
    .at_end(end_raw), .we(we_raw)
  );

  mcyc_seq_succ #(.N_STATES(N_STATES), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_succ (
    .st(st_q), .cond(cond_i), .nxt0_tbl(nxt0_tbl_i), .nxt1_tbl(nxt1_tbl_i),
    .sel_tbl(sel_tbl_i), .nxt_oh(nxt_oh), .nxt_sel(nxt_sel)
  );

  assign last_w = end_raw && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_INIT;
      sel_q <= sel_tbl_i[0 +: SEL_W];
    end else if (last_w) begin
      st_q  <= nxt_oh;
      sel_q <= nxt_sel;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt;
  assign last_o  = last_w;
  assign sel_o   = sel_q;
  assign we_o    = rst ? '0 : we_raw;

  // R1: exactly one state bit
  a_r1_onehot : assert property (@(posedge clk) disable iff (rst)
    $countones(st_q) == 1);
  // R3: state held until its final cycle
  a_r3_hold : assert property (@(posedge clk) disable iff (rst)
    !last_w |=> $stable(st_q));
  // R6: select word steady through a state
  a_r6_sel_steady : assert property (@(posedge clk) disable iff (rst)
    !last_w |=> $stable(sel_q));
  // R7: write enables only in a final cycle, so a new state follows
  a_r7_we_final : assert property (@(posedge clk) disable iff (rst)
    (we_o != '0) |=> cnt_o == '0);
endmodule

// File: tb/mcyc_onehot_seq_tb.sv
`timescale 1ns/1ps
module mcyc_onehot_seq_tb;
  localparam int N  = 6;
  localparam int IW = 3;
  localparam int CW = 5;
  localparam int SW = 4;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cond = 1'b0;
  logic [N*CW-1:0] dur_tbl;
  logic [N*IW-1:0] nxt0_tbl, nxt1_tbl;
  logic [N*SW-1:0] sel_tbl;
  logic [N*WW-1:0] we_tbl;
  logic [N-1:0]    state_o;
  logic [CW-1:0]   cnt_o;
  logic            last_o;
  logic [SW-1:0]   sel_o;
  logic [WW-1:0]   we_o;

  always #10 clk = ~clk;

  mcyc_onehot_seq #(.N_STATES(N), .IDX_W(IW), .SEL_W(SW), .WE_W(WW)) u_dut (
    .clk(clk), .rst(rst), .cond_i(cond), .dur_tbl_i(dur_tbl),
    .nxt0_tbl_i(nxt0_tbl), .nxt1_tbl_i(nxt1_tbl), .sel_tbl_i(sel_tbl),
    .we_tbl_i(we_tbl), .state_o(state_o), .cnt_o(cnt_o), .last_o(last_o),
    .sel_o(sel_o), .we_o(we_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // {cond, expected state index, expected count}
  localparam logic [8:0] VEC [14] = '{
    {1'b0, 3'd0, 5'd0}, {1'b0, 3'd1, 5'd0}, {1'b1, 3'd1, 5'd1},
    {1'b0, 3'd1, 5'd2}, {1'b1, 3'd2, 5'd0}, {1'b1, 3'd2, 5'd1},
    {1'b0, 3'd5, 5'd0}, {1'b0, 3'd0, 5'd0}, {1'b0, 3'd1, 5'd0},
    {1'b0, 3'd1, 5'd1}, {1'b0, 3'd1, 5'd2}, {1'b0, 3'd2, 5'd0},
    {1'b0, 3'd2, 5'd1}, {1'b0, 3'd0, 5'd0}
  };

  function automatic int dcode(int s);
    case (s)
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction
  function automatic int sel_of(int s); return s + 9; endfunction
  function automatic int we_of(int s);  return s + 1; endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic load_base();
    for (int i = 0; i < N; i++) begin
      dur_tbl[i*CW +: CW] = CW'(dcode(i));
      sel_tbl[i*SW +: SW] = SW'(sel_of(i));
      we_tbl[i*WW +: WW]  = WW'(we_of(i));
      nxt0_tbl[i*IW +: IW] = (i == 0) ? 3'd1 : (i == 1) ? 3'd2 : 3'd0;
      nxt1_tbl[i*IW +: IW] = (i == 0) ? 3'd1 : (i == 1) ? 3'd2 :
                             (i == 2) ? 3'd5 : 3'd0;
    end
  endtask

  task automatic expect_cycle(input int st, input int cn);
    int lst;
    lst = (cn == dcode(st)) ? 1 : 0;
    chk("R4 state", int'(state_o), 1 << st);
    chk("R2 count", int'(cnt_o), cn);
    chk("R3 last", int'(last_o), lst);
    chk("R6 sel", int'(sel_o), sel_of(st));
    chk("R7 we", int'(we_o), lst ? we_of(st) : 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    load_base();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 state", int'(state_o), 1);
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 sel", int'(sel_o), sel_of(0));
    chk("R1 we", int'(we_o), 0);
    chk("R1 last", int'(last_o), 0);
    rst = 1'b0;

    // table walk: R2 R3 R4 R6 R7, cond pulse in a non-final cycle (R8)
    for (int i = 0; i < 14; i++) begin
      if (i > 0) @(negedge clk);
      cond = VEC[i][8];
      #1;
      expect_cycle(int'(VEC[i][7:5]), int'(VEC[i][4:0]));
    end

    // R3 longest duration: 32 cycles, R6 mid-state table rewrite
    rst = 1'b1;
    cond = 1'b0;
    dur_tbl[0 +: CW] = 5'd31;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 10) sel_tbl[0 +: SW] = 4'd3;
      #1;
      chk("R3 long state", int'(state_o), 1);
      chk("R2 long count", int'(cnt_o), k);
      chk("R3 long last", int'(last_o), (k == 31) ? 1 : 0);
      chk("R6 sel held", int'(sel_o), sel_of(0));
    end
    @(negedge clk);
    #1;
    chk("R4 after long", int'(state_o), 2);
    chk("R2 after long", int'(cnt_o), 0);
    chk("R6 sel loaded", int'(sel_o), sel_of(1));
    sel_tbl[0 +: SW] = SW'(sel_of(0));
    dur_tbl[0 +: CW] = 5'd0;

    // R5 out-of-range successors fall back to state 0
    rst = 1'b1;
    nxt0_tbl[0 +: IW] = 3'd7;
    nxt1_tbl[0 +: IW] = 3'd6;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cond = 1'b0;
    #1;
    chk("R7 we state0", int'(we_o), we_of(0));
    @(negedge clk);
    cond = 1'b1;
    #1;
    chk("R5 idx7", int'(state_o), 1);
    chk("R5 idx7 count", int'(cnt_o), 0);
    @(negedge clk);
    #1;
    chk("R5 idx6", int'(state_o), 1);
    cond = 1'b0;
    nxt0_tbl[0 +: IW] = 3'd1;
    nxt1_tbl[0 +: IW] = 3'd1;

    // R1 reset in mid-run
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 rerst state", int'(state_o), 1);
    chk("R1 rerst count", int'(cnt_o), 0);
    chk("R1 rerst last", int'(last_o), 0);
    chk("R1 rerst we", int'(we_o), 0);
    chk("R1 rerst sel", int'(sel_o), sel_of(0));

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule